// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address for one request at a time. When translation is enabled and the access needs a walk, it reads descriptors from memory through a simple request/valid read port. It first reads a first-level entry, which may map a 4 MB superpage directly or point to a second-level table of 4 KB page entries. It then checks the read/write/execute permission bits of the final descriptor against the access kind for user-mode requests.

Each accepted request ends in exactly one one-cycle pulse. A `done` pulse comes with the physical address, a page-size flag and the permission bits. A `fault` pulse comes with a status code, the faulting virtual address and a trap class, which is instruction for execute accesses and data for all others. The status code and faulting address stay in registers until the next fault.

The control is a five-state machine:
- IDLE accepts a request.
- L1_READ holds the first-level read.
- L2_READ holds the second-level read.
- CHECK forms the address and applies the permission test.
- DONE drives the result pulse.

Transitions:
- IDLE→DONE on a bypass, which is translation off or a privileged lower-half access.
- IDLE→L1_READ on a walk.
- L1_READ→CHECK for a present superpage.
- L1_READ→L2_READ for a present table pointer.
- L1_READ→DONE on a first-level fault.
- L2_READ→CHECK for a present page.
- L2_READ→DONE on a second-level fault.
- CHECK→DONE always.
- DONE→IDLE always.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `done`, `fault` and `mem_req` are 0, and `fault_code` and `fault_vaddr` are 0.
- R2: With `xlate_en` low, a request completes with `resp_paddr` equal to the virtual address, `resp_perm` = 3'b111, `resp_super` = 0, and no memory read.
- R3: With `xlate_en` high, a privileged request (`req_user` = 0) whose address bit 31 is 0 completes with `resp_paddr` = the address with bit 31 set, `resp_perm` = 3'b111 and `resp_super` = 0, without a memory read. A user request to the same half is walked.
- R4: The first-level read address is {`tbl_base_hi`, vaddr[31:22], 2'b00}.
- R5: A first-level descriptor with type bits [1:0] = 2'b10 and present bit 2 set maps a superpage: `resp_paddr` = {desc[31:22], vaddr[21:0]}, `resp_super` = 1, `resp_perm` = desc[8:6] (bit 2 read, bit 1 write, bit 0 execute). If bit 2 is clear, the request faults with code 8'h0B.
- R6: A first-level descriptor with type 2'b00 faults with code 8'h05 when bit 2 is clear. When bit 2 is set, it causes a second read at {desc[31:12], vaddr[21:12], 2'b00}.
- R7: A second-level descriptor with bit 2 clear faults with code 8'h05+3 = 8'h08. With bit 2 set and type 2'b10, the request completes with `resp_paddr` = {desc[31:12], vaddr[11:0]}, `resp_super` = 0 and `resp_perm` = desc[8:6].
- R8: A first-level type of 2'b01 or 2'b11, or a present second-level descriptor whose type is not 2'b10, faults with code 8'h1F.
- R9: A user access faults when the final descriptor lacks the needed permission. A read (kind 0) needs desc[8] and faults with code 8'h11. A write (kind 1) needs desc[7] and faults with code 8'h12. An execute (kind 2) needs desc[6] and faults with code 8'h13. Kind 3 is treated as a read. Privileged accesses are never refused on permission bits.
- R10: On a fault, `fault_code` and `fault_vaddr` take the code and virtual address and hold them until the next fault. `trap_instr` is 1 exactly when the faulting access was an execute.
- R11: Every accepted request yields exactly one one-cycle pulse of either `done` or `fault`, never both. Requests are accepted only while `req_ready` is 1, which is only in IDLE.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen, so a read may take any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable |
| tbl_base_hi | input | 20 | First-level table base, bits [31:12] (4 KB aligned) |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 treated as read |
| req_user | input | 1 | 1 for a user-mode access, 0 for privileged |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Successful translation pulse |
| fault | output | 1 | Fault pulse |
| resp_paddr | output | 32 | Physical address, valid with done |
| resp_super | output | 1 | 1 for a 4 MB mapping, 0 for 4 KB |
| resp_perm | output | 3 | Permissions {read, write, execute}, valid with done |
| trap_instr | output | 1 | Trap class of the last fault: 1 instruction, 0 data |
| fault_code | output | 8 | Status code of the last fault |
| fault_vaddr | output | 32 | Virtual address of the last fault |

## Verification
The hardest conditions to reach from the ports are the second-level outcomes (page hit, page absent, wrong page type). Each needs a present pointer entry at one computed address and a chosen entry at a second address derived from that descriptor. A further hard case is a read held off for several cycles while `mem_req` must stay put. The bench places descriptors in a sparse memory image at addresses built from the table base and the request address. Its responder has an adjustable latency, so the same walks run with both immediate and delayed data. After a fault, a later successful walk shows that the latched code and address are left untouched.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int FC_W   = 8;
    localparam int PERM_W = 3;
    localparam int FRM_W  = VA_W - 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_READ, ST_L2_READ, ST_CHECK, ST_DONE
    } ptw_state_e;

    typedef enum logic [1:0] {
        EV_SUPER, EV_NEXT, EV_PAGE, EV_FAULT
    } eval_e;

    localparam logic [1:0] TY_BIG  = 2'b10;
    localparam logic [1:0] TY_PTR  = 2'b00;
    localparam logic [1:0] TY_LEAF = 2'b10;

    localparam logic [FC_W-1:0] FC_NONE          = 8'h00;
    localparam logic [FC_W-1:0] FC_TABLE_ABSENT  = 8'h05;
    localparam logic [FC_W-1:0] FC_PAGE_ABSENT   = 8'h08;
    localparam logic [FC_W-1:0] FC_SUPER_ABSENT  = 8'h0B;
    localparam logic [FC_W-1:0] FC_NO_READ       = 8'h11;
    localparam logic [FC_W-1:0] FC_NO_WRITE      = 8'h12;
    localparam logic [FC_W-1:0] FC_NO_EXEC       = 8'h13;
    localparam logic [FC_W-1:0] FC_BAD_TYPE      = 8'h1F;
endpackage

// File: rtl/ptw_desc_eval.sv
`timescale 1ns/1ps
module ptw_desc_eval
    import ptw_pkg::*;
(
    input  logic [2:0]      desc_lo,
    input  logic            second_lvl,
    output eval_e           outcome,
    output logic [FC_W-1:0] code
);
    always_comb begin
        outcome = EV_FAULT;
        code    = FC_BAD_TYPE;
        if (!second_lvl) begin
            unique case (desc_lo[1:0])
                TY_BIG: begin
                    if (desc_lo[2]) begin
                        outcome = EV_SUPER;
                        code    = FC_NONE;
                    end else begin
                        code = FC_SUPER_ABSENT;
                    end
                end
                TY_PTR: begin
                    if (desc_lo[2]) begin
                        outcome = EV_NEXT;
                        code    = FC_NONE;
                    end else begin
                        code = FC_TABLE_ABSENT;
                    end
                end
                default: ;
            endcase
        end else if (!desc_lo[2]) begin
            code = FC_PAGE_ABSENT;
        end else if (desc_lo[1:0] == TY_LEAF) begin
            outcome = EV_PAGE;
            code    = FC_NONE;
        end
    end
endmodule

// File: rtl/ptw_perm_check.sv
`timescale 1ns/1ps
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic [1:0]        kind,
    input  logic              user,
    output logic              deny,
    output logic [FC_W-1:0]   code
);
    logic need;

    always_comb begin
        unique case (kind)
            2'd1: begin
                need = perm[1];
                code = FC_NO_WRITE;
            end
            2'd2: begin
                need = perm[0];
                code = FC_NO_EXEC;
            end
            default: begin
                need = perm[2];
                code = FC_NO_READ;
            end
        endcase
        deny = user && !need;
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic [FRM_W-1:0]  tbl_base_hi,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [VA_W-1:0]   mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [VA_W-1:0]   resp_paddr,
    output logic              resp_super,
    output logic [PERM_W-1:0] resp_perm,
    output logic              trap_instr,
    output logic [FC_W-1:0]   fault_code,
    output logic [VA_W-1:0]   fault_vaddr
);
    ptw_state_e state_q, state_d;

    logic [VA_W-1:0]   vaddr_q, walk_addr_q, paddr_q, fva_q;
    logic [1:0]        kind_q;
    logic              user_q, super_q, flt_q, trap_q;
    logic [FRM_W-1:0]  frame_q;
    logic [PERM_W-1:0] dperm_q, perm_q;
    logic [FC_W-1:0]   fcode_q;

    eval_e             ev_outcome;
    logic [FC_W-1:0]   ev_code;
    logic              pc_deny;
    logic [FC_W-1:0]   pc_code;
    logic              rec_fault;
    logic [FC_W-1:0]   rec_code;
    logic              bypass;
    logic              unused_desc_bits;

    assign unused_desc_bits = ^{mem_rdata[11:9], mem_rdata[5:3]};

    ptw_desc_eval u_eval (
        .desc_lo    (mem_rdata[2:0]),
        .second_lvl (state_q == ST_L2_READ),
        .outcome    (ev_outcome),
        .code       (ev_code)
    );

    ptw_perm_check u_perm (
        .perm (dperm_q),
        .kind (kind_q),
        .user (user_q),
        .deny (pc_deny),
        .code (pc_code)
    );

    assign bypass = !xlate_en || (!req_user && !req_vaddr[VA_W-1]);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = bypass ? ST_DONE : ST_L1_READ;
            ST_L1_READ: if (mem_valid) begin
                unique case (ev_outcome)
                    EV_SUPER: state_d = ST_CHECK;
                    EV_NEXT:  state_d = ST_L2_READ;
                    default:  state_d = ST_DONE;
                endcase
            end
            ST_L2_READ: if (mem_valid) state_d = (ev_outcome == EV_PAGE) ? ST_CHECK : ST_DONE;
            ST_CHECK:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rec_fault = ((state_q == ST_L1_READ) && mem_valid && (ev_outcome == EV_FAULT))
                 || ((state_q == ST_L2_READ) && mem_valid && (ev_outcome != EV_PAGE))
                 || ((state_q == ST_CHECK) && pc_deny);
        rec_code  = (state_q == ST_CHECK) ? pc_code : ev_code;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            walk_addr_q <= '0;
            paddr_q     <= '0;
            kind_q      <= '0;
            user_q      <= 1'b0;
            super_q     <= 1'b0;
            flt_q       <= 1'b0;
            trap_q      <= 1'b0;
            frame_q     <= '0;
            dperm_q     <= '0;
            perm_q      <= '0;
            fcode_q     <= '0;
            fva_q       <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                vaddr_q     <= req_vaddr;
                kind_q      <= req_kind;
                user_q      <= req_user;
                walk_addr_q <= {tbl_base_hi, req_vaddr[VA_W-1:22], 2'b00};
                flt_q       <= 1'b0;
                super_q     <= 1'b0;
                perm_q      <= '1;
                paddr_q     <= xlate_en ? {1'b1, req_vaddr[VA_W-2:0]} : req_vaddr;
            end
            if ((state_q == ST_L1_READ || state_q == ST_L2_READ) && mem_valid) begin
                frame_q <= mem_rdata[VA_W-1:12];
                dperm_q <= mem_rdata[8:6];
                if (ev_outcome == EV_SUPER) super_q <= 1'b1;
                if (ev_outcome == EV_NEXT)
                    walk_addr_q <= {mem_rdata[VA_W-1:12], vaddr_q[21:12], 2'b00};
            end
            if (state_q == ST_CHECK) begin
                perm_q  <= dperm_q;
                paddr_q <= super_q ? {frame_q[FRM_W-1:10], vaddr_q[21:0]}
                                   : {frame_q, vaddr_q[11:0]};
            end
            if (rec_fault) begin
                flt_q   <= 1'b1;
                fcode_q <= rec_code;
                fva_q   <= vaddr_q;
                trap_q  <= (kind_q == 2'd2);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_req     = (state_q == ST_L1_READ) || (state_q == ST_L2_READ);
        mem_addr    = walk_addr_q;
        done        = (state_q == ST_DONE) && !flt_q;
        fault       = (state_q == ST_DONE) && flt_q;
        resp_paddr  = paddr_q;
        resp_super  = super_q;
        resp_perm   = perm_q;
        trap_instr  = trap_q;
        fault_code  = fcode_q;
        fault_vaddr = fva_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xlate_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_user,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        done,
    input logic        fault,
    input logic [7:0]  fault_code,
    input logic [31:0] fault_vaddr
);
    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R11
    ready_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> req_ready);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R2
    xlate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlate_en) |=> (done && !mem_req));

    // R3
    low_half_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xlate_en && !req_user && !req_vaddr[31])
        |=> (done && !mem_req));

    // R10
    fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fault_code) || !$stable(fault_vaddr)) |-> fault);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xlate_en    (xlate_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .req_user    (req_user),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .done        (done),
    .fault       (fault),
    .fault_code  (fault_code),
    .fault_vaddr (fault_vaddr)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic [19:0] tbl_base_hi = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, resp_super, trap_instr;
    logic [31:0] resp_paddr, fault_vaddr;
    logic [2:0]  resp_perm;
    logic [7:0]  fault_code;

    ptw_walker uut (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        bit          flt;
        logic [7:0]  code;
        logic [31:0] va;
        logic [31:0] pa;
        bit          sup;
        logic [2:0]  perm;
        bit          trap;
    } exp_t;

    exp_t        exp_q[$];
    string       tag_q[$];
    logic [31:0] rd_q[$];
    logic [31:0] mem_img [logic [31:0]];
    int          n_chk = 0, n_err = 0, n_issued = 0, n_resp = 0;
    int          mem_lat = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mk(input logic [31:0] frame, input logic [2:0] p,
                                       input bit pres, input logic [1:0] ty);
        return frame | ({29'h0, p} << 6) | ({31'h0, pres} << 2) | {30'h0, ty};
    endfunction

    // expected result built from the requirements
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] k, input bit u);
        exp_t e;
        logic [31:0] d1, d2, dfin;
        bit need;
        e.flt = 0; e.code = 8'h00; e.va = va; e.pa = va; e.sup = 0;
        e.perm = 3'b111; e.trap = (k == 2'd2);
        if (!xlate_en) return e;
        if (!u && !va[31]) begin e.pa = va | 32'h8000_0000; return e; end
        d1 = rd({tbl_base_hi, va[31:22], 2'b00});
        if (d1[1:0] == 2'b10) begin
            if (!d1[2]) begin e.flt = 1; e.code = 8'h0B; return e; end
            dfin = d1; e.sup = 1; e.pa = {d1[31:22], va[21:0]};
        end else if (d1[1:0] == 2'b00) begin
            if (!d1[2]) begin e.flt = 1; e.code = 8'h05; return e; end
            d2 = rd({d1[31:12], va[21:12], 2'b00});
            if (!d2[2]) begin e.flt = 1; e.code = 8'h08; return e; end
            if (d2[1:0] != 2'b10) begin e.flt = 1; e.code = 8'h1F; return e; end
            dfin = d2; e.pa = {d2[31:12], va[11:0]};
        end else begin
            e.flt = 1; e.code = 8'h1F; return e;
        end
        e.perm = dfin[8:6];
        need = (k == 2'd1) ? dfin[7] : (k == 2'd2) ? dfin[6] : dfin[8];
        if (u && !need) begin
            e.flt = 1;
            e.code = (k == 2'd1) ? 8'h12 : (k == 2'd2) ? 8'h13 : 8'h11;
        end
        return e;
    endfunction

    task automatic issue(input logic [31:0] va, input logic [1:0] k, input bit u, input string tag);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(model(va, k, u));
        tag_q.push_back(tag);
        n_issued++;
        req_vaddr = va; req_kind = k; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // memory responder
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_valid) mem_valid = 1'b0;
            else if (mem_req) begin
                if (cnt >= mem_lat) begin
                    mem_valid = 1'b1;
                    mem_rdata = rd(mem_addr);
                    rd_q.push_back(mem_addr);
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (done || fault)) begin
                n_resp++;
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected result pulse", {31'h0, done}, 32'h0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e.flt) begin
                        chk(fault === 1'b1 && done === 1'b0, {t, " fault pulse"}, {31'h0, fault}, 32'h1);
                        chk(fault_code === e.code, {t, " code"}, {24'h0, fault_code}, {24'h0, e.code});
                        chk(fault_vaddr === e.va, {t, " R10 fault vaddr"}, fault_vaddr, e.va);
                        chk(trap_instr === e.trap, {t, " R10 trap class"}, {31'h0, trap_instr}, {31'h0, e.trap});
                    end else begin
                        chk(done === 1'b1 && fault === 1'b0, {t, " done pulse"}, {31'h0, done}, 32'h1);
                        chk(resp_paddr === e.pa, {t, " paddr"}, resp_paddr, e.pa);
                        chk(resp_super === e.sup, {t, " size"}, {31'h0, resp_super}, {31'h0, e.sup});
                        chk(resp_perm === e.perm, {t, " perm"}, {29'h0, resp_perm}, {29'h0, e.perm});
                    end
                end
            end
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] va, l2a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 ready", {31'h0, req_ready}, 32'h1);
        chk(done === 1'b0 && fault === 1'b0, "R1 no pulse", {30'h0, done, fault}, 32'h0);
        chk(mem_req === 1'b0, "R1 mem_req", {31'h0, mem_req}, 32'h0);
        chk(fault_code === 8'h0 && fault_vaddr === 32'h0, "R1 fault regs", fault_vaddr, 32'h0);

        // R2 translation off
        rd_q.delete();
        issue(32'h1234_5678, 2'd0, 1'b1, "R2 passthrough");
        issue(32'hF00D_0ABC, 2'd2, 1'b0, "R2 passthrough priv");
        chk(rd_q.size() == 0, "R2 no read", rd_q.size(), 0);

        xlate_en = 1'b1;
        // R3 privileged lower half bypass
        rd_q.delete();
        issue(32'h0012_3456, 2'd2, 1'b0, "R3 bypass");
        chk(rd_q.size() == 0, "R3 no read", rd_q.size(), 0);

        // R5 superpage, R4 first-level address
        va = 32'h8040_1234;
        mem_img[{tbl_base_hi, va[31:22], 2'b00}] = mk(32'h1230_0000, 3'b111, 1, 2'b10);
        rd_q.delete();
        issue(va, 2'd0, 1'b1, "R5 superpage");
        chk(rd_q.size() == 1 && rd_q[0] == {tbl_base_hi, va[31:22], 2'b00}, "R4 L1 address",
            rd_q.size() > 0 ? rd_q[0] : 32'hx, {tbl_base_hi, va[31:22], 2'b00});

        // R3 user access to lower half is walked
        va = 32'h0040_0000;
        mem_img[{tbl_base_hi, va[31:22], 2'b00}] = mk(32'h7000_0000, 3'b111, 1, 2'b10);
        rd_q.delete();
        issue(va | 32'h55, 2'd1, 1'b1, "R3 user low half walk");
        chk(rd_q.size() == 1, "R3 user walk read", rd_q.size(), 1);

        // R9 read-only superpage
        va = 32'h80C0_0010;
        mem_img[{tbl_base_hi, va[31:22], 2'b00}] = mk(32'h4000_0000, 3'b100, 1, 2'b10);
        issue(va, 2'd1, 1'b1, "R9 user write denied");
        issue(va, 2'd2, 1'b1, "R9 user exec denied");
        issue(va, 2'd3, 1'b1, "R9 kind3 as read");
        issue(va, 2'd1, 1'b0, "R9 priv write allowed");

        // R5 absent superpage, execute (R10 instruction trap)
        va = 32'h8100_0000;
        mem_img[{tbl_base_hi, va[31:22], 2'b00}] = mk(32'h0, 3'b111, 0, 2'b10);
        issue(va, 2'd2, 1'b0, "R5 absent superpage");

        // R6 absent pointer (unmapped entry reads as zero)
        issue(32'h9000_0004, 2'd0, 1'b1, "R6 absent table");

        // R7 4 KB page through a second-level table
        va = 32'hA012_3ABC;
        mem_img[{tbl_base_hi, va[31:22], 2'b00}] = mk(32'h0020_0000, 3'b000, 1, 2'b00);
        l2a = {20'h00200, va[21:12], 2'b00};
        mem_img[l2a] = mk(32'h5555_5000, 3'b011, 1, 2'b10);
        rd_q.delete();
        issue(va, 2'd1, 1'b1, "R7 page write");
        chk(rd_q.size() == 2 && rd_q[1] == l2a, "R6 L2 address",
            rd_q.size() > 1 ? rd_q[1] : 32'hx, l2a);
        issue(va, 2'd0, 1'b1, "R9 page read denied");
        issue(va, 2'd2, 1'b1, "R7 page exec");

        // R10 fault registers held across a success
        chk(fault_code === 8'h11 && fault_vaddr === va, "R10 hold after success",
            {24'h0, fault_code}, 32'h11);

        // R7 absent page, R8 bad types
        issue(32'hA012_4000, 2'd0, 1'b0, "R7 absent page");
        mem_img[{20'h00200, 10'h125, 2'b00}] = mk(32'h6000_0000, 3'b111, 1, 2'b00);
        issue(32'hA012_5000, 2'd0, 1'b0, "R8 bad L2 type");
        mem_img[{tbl_base_hi, 10'h2C0, 2'b00}] = mk(32'h0, 3'b111, 1, 2'b01);
        issue(32'hB000_0000, 2'd1, 1'b1, "R8 bad L1 type 01");
        mem_img[{tbl_base_hi, 10'h2C4, 2'b00}] = mk(32'h0, 3'b111, 1, 2'b11);
        issue(32'hB100_0000, 2'd0, 1'b1, "R8 bad L1 type 11");

        // R12 delayed memory data
        mem_lat = 3;
        issue(32'hA012_3FF0, 2'd1, 1'b1, "R12 slow page walk");
        issue(32'h8040_0008, 2'd0, 1'b1, "R12 slow superpage");
        mem_lat = 0;

        // R2 again after translation was on
        xlate_en = 1'b0;
        issue(32'h0000_1000, 2'd1, 1'b1, "R2 off again");

        repeat (4) @(negedge clk);
        chk(n_resp == n_issued, "R11 one result per request", n_resp, n_issued);
        summary();
        $finish;
    end
endmodule